// File: doc/BRIEF.md
# Power-on calibration load sequencer

This block runs the chip's startup after a power-on reset. It first holds a startup mode with the internal oscillator gate closed. It then opens the gate and transfers a fixed set of 188 constant words from one-time-programmable (OTP) storage into the working trim and calibration registers, one word per copy pulse. Each copy pulse is shown on an active-low interrupt pin, so a host controller can watch the load happen.

Once the last word is written, the block watches an external clock input for a short window of internal clock cycles. It then settles in one of two final modes:
- If no external clock is found, it enters a wake-up mode and loads only the default comparison threshold.
- If an external clock is found, it enters a current-measurement mode with a full default configuration.

One gain-calibration slot is always written as zero rather than copied. With that slot at zero, the measurement result reads zero until the host copies the proper factor into it. The host can use this to detect an unexpected reset. After the load, the block stops driving the register write port, so the host is free to rewrite the registers.

Top module: `boot_cal_loader`

## Requirements
- R1: While `rst_n` is low, and for the cycles in which its synchronized copy is still low, the block holds: `mode` = 2'b00 (startup), `clk_en` = 0, `int_n` = 1, `reg_we` = 0, `load_done` = 0, and all default-configuration outputs at zero. Asserting `rst_n` takes effect without waiting for a clock edge.
- R2: After reset release, the block spends one cycle in startup mode. It then drives `clk_en` = 1 and `mode` = 2'b01 (loading) until the final mode is chosen.
- R3: Copy pulse k (k = 0 to 187, in increasing order) drives `otp_addr` = k and writes OTP word k to `reg_addr` = k. `reg_bank` = 0 (trim register) for k < 60 and `reg_bank` = 1 (calibration register) for k >= 60.
- R4: Exactly 188 copy pulses are produced. Each pulse is `int_n` low for one internal clock period, followed by one period high. `reg_we` is high exactly in the cycles where `int_n` is low.
- R5: The write for word index 150 (the selected gain-calibration factor slot) carries data 0, whatever the OTP holds at that address.
- R6: `load_done` rises after the 188th pulse and stays high until the next reset.
- R7: After the load, the external clock is watched for 16 internal clock cycles. At least 4 rising edges seen in that window select measurement mode (`mode` = 2'b11). Fewer select wake-up mode (`mode` = 2'b10).
- R8: Both final modes set `thr_val` = 16384.
- R9: Measurement mode also sets `gain_code` = 100, `ovs_khz` = 4096, `dec1` = 64, `mm_cfg` = 4 and `dec2` = 1. In wake-up mode these outputs remain 0.
- R10: Once in a final mode, the block keeps that mode and never asserts `reg_we` or pulls `int_n` low again until reset.
- R11: Asserting `rst_n` in the middle of the load aborts it. After release, the sequence starts again from the startup mode and from word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_int | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ext_clk | input | 1 | External clock, asynchronous, probed for presence |
| otp_addr | output | 8 | OTP read address (current word index) |
| otp_rdata | input | 16 | OTP read data, combinational from otp_addr |
| reg_we | output | 1 | Working-register write strobe |
| reg_bank | output | 1 | Target register: 0 trim, 1 calibration |
| reg_addr | output | 8 | Word index being written |
| reg_wdata | output | 16 | Word written |
| int_n | output | 1 | Active-low interrupt pin mirroring copy pulses |
| clk_en | output | 1 | Internal oscillator enable |
| mode | output | 2 | 00 startup, 01 loading, 10 wake-up, 11 measurement |
| load_done | output | 1 | Copy sequence completed |
| thr_val | output | 16 | Default threshold value |
| gain_code | output | 8 | Default gain setting |
| ovs_khz | output | 13 | Default oversampling clock in kHz |
| dec1 | output | 8 | Default first decimation ratio |
| mm_cfg | output | 3 | Default mode setting |
| dec2 | output | 8 | Default second decimation ratio |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of the copy burst. After it, the restarted sequence must begin again at word 0 and not carry on from the old count.

The stimulus reaches this case by starting a normal load and letting about a hundred cycles of copy pulses go by. It then pulls `rst_n` low without waiting for a clock edge and checks the startup outputs at once. Next it flushes and refills the scoreboard, releases reset, and requires the full 188-word sequence to start over. The external-clock decision is driven with three patterns: a fast clock, a clock too slow to reach four edges in the window, and no clock at all.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [1:0] {
    MODE_BOOT = 2'b00,
    MODE_LOAD = 2'b01,
    MODE_WAKE = 2'b10,
    MODE_MEAS = 2'b11
  } mode_t;

  typedef enum logic [2:0] {
    ST_BOOT  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_PROBE = 3'd2,
    ST_WAKE  = 3'd3,
    ST_MEAS  = 3'd4
  } seq_state_t;

  localparam logic [15:0] DEF_THR     = 16'd16384;
  localparam logic [7:0]  DEF_GAIN    = 8'd100;
  localparam logic [12:0] DEF_OVS_KHZ = 13'd4096;
  localparam logic [7:0]  DEF_DEC1    = 8'd64;
  localparam logic [2:0]  DEF_MM      = 3'd4;
  localparam logic [7:0]  DEF_DEC2    = 8'd1;

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/boot_pulse_ctr.sv
module boot_pulse_ctr #(
  parameter int N_WORDS = 188,
  parameter int AW      = $clog2(N_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [AW-1:0] idx,
  output logic          low_ph,
  output logic          last
);

  localparam logic [AW-1:0] LAST_IDX = AW'(N_WORDS - 1);

  logic [AW-1:0] idx_q, idx_d;
  logic          ph_q, ph_d;

  always_comb begin
    idx_d = idx_q;
    ph_d  = ph_q;
    if (!run) begin
      idx_d = '0;
      ph_d  = 1'b0;
    end else if (!ph_q) begin
      ph_d = 1'b1;
    end else begin
      ph_d = 1'b0;
      if (idx_q != LAST_IDX) idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      idx_q <= idx_d;
      ph_q  <= ph_d;
    end
  end

  assign idx    = idx_q;
  assign low_ph = run && !ph_q;
  assign last   = run && ph_q && (idx_q == LAST_IDX);

endmodule

// File: rtl/boot_ext_probe.sv
module boot_ext_probe #(
  parameter int WIN_CYC   = 16,
  parameter int MIN_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_async,
  input  logic active,
  output logic win_done,
  output logic present
);

  localparam int WW = $clog2(WIN_CYC);
  localparam int EW = $clog2(MIN_EDGES + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYC - 1);
  localparam logic [EW-1:0] EDGE_SAT = EW'(MIN_EDGES);

  logic [2:0]    sync_q;
  logic [WW-1:0] win_q, win_d;
  logic [EW-1:0] edg_q, edg_d;
  logic          rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_async};
  end

  assign rise = sync_q[1] && !sync_q[2];

  always_comb begin
    win_d = '0;
    edg_d = '0;
    if (active) begin
      win_d = (win_q == WIN_LAST) ? win_q : win_q + 1'b1;
      edg_d = edg_q;
      if (rise && (edg_q != EDGE_SAT)) edg_d = edg_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      edg_q <= '0;
    end else begin
      win_q <= win_d;
      edg_q <= edg_d;
    end
  end

  assign win_done = active && (win_q == WIN_LAST);
  assign present  = (edg_q == EDGE_SAT);

endmodule

// File: rtl/boot_cal_loader.sv
module boot_cal_loader
  import boot_pkg::*;
#(
  parameter int N_WORDS    = 188,
  parameter int TRIM_WORDS = 60,
  parameter int ZERO_IDX   = 150,
  parameter int DW         = 16,
  parameter int AW         = 8,
  parameter int WIN_CYC    = 16,
  parameter int MIN_EDGES  = 4
) (
  input  logic          clk_int,
  input  logic          rst_n,
  input  logic          ext_clk,
  output logic [AW-1:0] otp_addr,
  input  logic [DW-1:0] otp_rdata,
  output logic          reg_we,
  output logic          reg_bank,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          int_n,
  output logic          clk_en,
  output logic [1:0]    mode,
  output logic          load_done,
  output logic [15:0]   thr_val,
  output logic [7:0]    gain_code,
  output logic [12:0]   ovs_khz,
  output logic [7:0]    dec1,
  output logic [2:0]    mm_cfg,
  output logic [7:0]    dec2
);

  localparam logic [AW-1:0] TRIM_END = AW'(TRIM_WORDS);
  localparam logic [AW-1:0] ZERO_AT  = AW'(ZERO_IDX);

  logic          srst_n;
  seq_state_t    st_q, st_d;
  logic [AW-1:0] idx;
  logic          low_ph, last;
  logic          win_done, present;
  logic          cfg_upd, meas_upd;

  logic [15:0] thr_q;
  logic [7:0]  gain_q, dec1_q, dec2_q;
  logic [12:0] ovs_q;
  logic [2:0]  mm_q;

  boot_rst_sync #(.STAGES(2)) u_rsync (
    .clk       (clk_int),
    .rst_n_in  (rst_n),
    .rst_n_out (srst_n)
  );

  boot_pulse_ctr #(.N_WORDS(N_WORDS), .AW(AW)) u_pulse (
    .clk    (clk_int),
    .rst_n  (srst_n),
    .run    (st_q == ST_LOAD),
    .idx    (idx),
    .low_ph (low_ph),
    .last   (last)
  );

  boot_ext_probe #(.WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES)) u_probe (
    .clk       (clk_int),
    .rst_n     (srst_n),
    .ext_async (ext_clk),
    .active    (st_q == ST_PROBE),
    .win_done  (win_done),
    .present   (present)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_BOOT:  st_d = ST_LOAD;
      ST_LOAD:  if (last) st_d = ST_PROBE;
      ST_PROBE: if (win_done) st_d = present ? ST_MEAS : ST_WAKE;
      ST_WAKE:  st_d = ST_WAKE;
      ST_MEAS:  st_d = ST_MEAS;
      default:  st_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk_int or negedge srst_n) begin
    if (!srst_n) st_q <= ST_BOOT;
    else         st_q <= st_d;
  end

  // default configuration registers with explicit enables
  assign cfg_upd  = (st_q == ST_PROBE) && win_done;
  assign meas_upd = cfg_upd && present;

  always_ff @(posedge clk_int or negedge srst_n) begin
    if (!srst_n) thr_q <= '0;
    else if (cfg_upd) thr_q <= DEF_THR;
  end

  always_ff @(posedge clk_int or negedge srst_n) begin
    if (!srst_n) begin
      gain_q <= '0;
      ovs_q  <= '0;
      dec1_q <= '0;
      mm_q   <= '0;
      dec2_q <= '0;
    end else if (meas_upd) begin
      gain_q <= DEF_GAIN;
      ovs_q  <= DEF_OVS_KHZ;
      dec1_q <= DEF_DEC1;
      mm_q   <= DEF_MM;
      dec2_q <= DEF_DEC2;
    end
  end

  // outputs
  always_comb begin
    unique case (st_q)
      ST_BOOT:           mode = MODE_BOOT;
      ST_LOAD, ST_PROBE: mode = MODE_LOAD;
      ST_WAKE:           mode = MODE_WAKE;
      ST_MEAS:           mode = MODE_MEAS;
      default:           mode = MODE_BOOT;
    endcase
  end

  assign clk_en    = (st_q != ST_BOOT);
  assign load_done = (st_q == ST_PROBE) || (st_q == ST_WAKE) || (st_q == ST_MEAS);
  assign otp_addr  = idx;
  assign reg_we    = low_ph;
  assign int_n     = !low_ph;
  assign reg_addr  = idx;
  assign reg_bank  = (idx >= TRIM_END);
  assign reg_wdata = (idx == ZERO_AT) ? '0 : otp_rdata;

  assign thr_val   = thr_q;
  assign gain_code = gain_q;
  assign ovs_khz   = ovs_q;
  assign dec1      = dec1_q;
  assign mm_cfg    = mm_q;
  assign dec2      = dec2_q;

endmodule

// File: rtl/boot_cal_loader_chk.sv
module boot_cal_loader_chk #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int ZERO_IDX = 150
) (
  input logic          clk_int,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          int_n,
  input logic [1:0]    mode,
  input logic          load_done,
  input logic [7:0]    gain_code
);

  // R4
  pulse_gap_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    !int_n |=> int_n);

  // R3
  addr_step_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    (reg_we && $past(reg_we, 2)) |-> (reg_addr == $past(reg_addr, 2) + 1'b1));

  // R5
  zero_slot_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(ZERO_IDX)) |-> (reg_wdata == '0));

  // R10
  final_hold_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    mode[1] |=> (mode == $past(mode)) && !reg_we);

  // R6
  done_sticky_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    load_done |=> load_done);

  // R9
  meas_gain_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    (mode == 2'b11) |-> (gain_code == 8'd100));

endmodule

bind boot_cal_loader boot_cal_loader_chk #(.AW(AW), .DW(DW), .ZERO_IDX(ZERO_IDX)) i_chk (
  .clk_int   (clk_int),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .int_n     (int_n),
  .mode      (mode),
  .load_done (load_done),
  .gain_code (gain_code)
);

// File: tb/test_boot_cal_loader.sv
`timescale 1ns/1ps
module test_boot_cal_loader;

  typedef struct packed {
    logic        bank;
    logic [7:0]  addr;
    logic [15:0] data;
  } wr_item_t;

  logic        clk_int = 1'b0;
  logic        rst_n;
  logic        ext_clk = 1'b0;
  logic [7:0]  otp_addr;
  logic [15:0] otp_rdata;
  logic        reg_we, reg_bank, int_n, clk_en, load_done;
  logic [7:0]  reg_addr, gain_code, dec1, dec2;
  logic [15:0] reg_wdata, thr_val;
  logic [1:0]  mode;
  logic [12:0] ovs_khz;
  logic [2:0]  mm_cfg;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit ext_on = 1'b0;
  int ext_half = 13;
  wr_item_t exp_q[$];

  always #5 clk_int = ~clk_int;

  always begin
    #(ext_half);
    if (ext_on) ext_clk = ~ext_clk;
    else        ext_clk = 1'b0;
  end

  function automatic logic [15:0] otp_word(input logic [7:0] a);
    return (16'(a) * 16'h9E37) ^ 16'h5A5A;
  endfunction

  assign otp_rdata = otp_word(otp_addr);

  boot_cal_loader i_boot_cal_loader (
    .clk_int(clk_int), .rst_n(rst_n), .ext_clk(ext_clk),
    .otp_addr(otp_addr), .otp_rdata(otp_rdata),
    .reg_we(reg_we), .reg_bank(reg_bank), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .int_n(int_n), .clk_en(clk_en), .mode(mode), .load_done(load_done),
    .thr_val(thr_val), .gain_code(gain_code), .ovs_khz(ovs_khz),
    .dec1(dec1), .mm_cfg(mm_cfg), .dec2(dec2)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver: expected write stream, R3 and R5
  task automatic expect_load();
    exp_q.delete();
    for (int k = 0; k < 188; k++) begin
      wr_item_t it;
      it.bank = (k >= 60);
      it.addr = 8'(k);
      it.data = (k == 150) ? 16'h0000 : otp_word(8'(k));
      exp_q.push_back(it);
    end
  endtask

  // monitor: compare writes, count pulses
  always @(negedge clk_int) begin
    if (rst_n) begin
      if (!int_n) pulses++;
      if (reg_we != !int_n)
        check(1'b0, "R4 we/int_n mismatch", int'(reg_we), int'(!int_n));
      if (reg_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected write", int'(reg_addr), -1);
        end else begin
          wr_item_t e;
          e = exp_q.pop_front();
          check(reg_addr == e.addr, "R3 addr", int'(reg_addr), int'(e.addr));
          check(otp_addr == e.addr, "R3 otp_addr", int'(otp_addr), int'(e.addr));
          check(reg_bank == e.bank, "R3 bank", int'(reg_bank), int'(e.bank));
          check(reg_wdata == e.data, (e.addr == 8'd150) ? "R5 zero slot" : "R3 data",
                int'(reg_wdata), int'(e.data));
        end
      end
    end
  end

  task automatic wait_final();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_int);
      if (mode[1]) return;
    end
    check(1'b0, "R7 no final mode", int'(mode), 2);
  endtask

  task automatic start_run();
    pulses = 0;
    expect_load();
    @(negedge clk_int);
    rst_n = 1'b1;
    repeat (6) @(negedge clk_int);
    check(mode == 2'b01, "R2 mode loading", int'(mode), 1);
    check(clk_en == 1'b1, "R2 clk_en", int'(clk_en), 1);
    check(load_done == 1'b0, "R6 done early", int'(load_done), 0);
  endtask

  task automatic do_reset();
    @(negedge clk_int);
    rst_n = 1'b0;
    repeat (3) @(negedge clk_int);
  endtask

  task automatic check_tail(input bit meas);
    check(pulses == 188, "R4 pulse count", pulses, 188);
    check(exp_q.size() == 0, "R3 writes left", exp_q.size(), 0);
    check(load_done == 1'b1, "R6 done", int'(load_done), 1);
    check(thr_val == 16'd16384, "R8 threshold", int'(thr_val), 16384);
    if (meas) begin
      check(mode == 2'b11, "R7 meas mode", int'(mode), 3);
      check(gain_code == 8'd100, "R9 gain", int'(gain_code), 100);
      check(ovs_khz == 13'd4096, "R9 ovs", int'(ovs_khz), 4096);
      check(dec1 == 8'd64, "R9 dec1", int'(dec1), 64);
      check(mm_cfg == 3'd4, "R9 mm", int'(mm_cfg), 4);
      check(dec2 == 8'd1, "R9 dec2", int'(dec2), 1);
    end else begin
      check(mode == 2'b10, "R7 wake mode", int'(mode), 2);
      check(gain_code == 8'd0, "R9 wake gain", int'(gain_code), 0);
      check(dec1 == 8'd0, "R9 wake dec1", int'(dec1), 0);
    end
    repeat (40) @(negedge clk_int);
    check(pulses == 188, "R10 no extra pulses", pulses, 188);
    check(mode == (meas ? 2'b11 : 2'b10), "R10 mode held", int'(mode), meas ? 3 : 2);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk_int);
    // R1 reset state
    check(mode == 2'b00, "R1 mode", int'(mode), 0);
    check(clk_en == 1'b0, "R1 clk_en", int'(clk_en), 0);
    check(int_n == 1'b1, "R1 int_n", int'(int_n), 1);
    check(reg_we == 1'b0, "R1 reg_we", int'(reg_we), 0);
    check(load_done == 1'b0, "R1 done", int'(load_done), 0);
    check(thr_val == 16'd0, "R1 thr", int'(thr_val), 0);

    // fast external clock -> measurement (R7, R9)
    ext_half = 13; ext_on = 1'b1;
    start_run();
    wait_final();
    check_tail(1'b1);

    // no external clock -> wake-up
    do_reset();
    ext_on = 1'b0;
    start_run();
    wait_final();
    check_tail(1'b0);

    // slow external clock, too few edges -> wake-up
    do_reset();
    ext_half = 60; ext_on = 1'b1;
    start_run();
    wait_final();
    check_tail(1'b0);

    // R11 reset in the middle of the load
    do_reset();
    ext_half = 13; ext_on = 1'b1;
    start_run();
    repeat (100) @(negedge clk_int);
    check(pulses > 20 && pulses < 188, "R11 mid-load", pulses, 50);
    #2 rst_n = 1'b0;
    #1;
    check(mode == 2'b00, "R11 R1 async mode", int'(mode), 0);
    check(int_n == 1'b1, "R11 R1 async int_n", int'(int_n), 1);
    check(load_done == 1'b0, "R11 done cleared", int'(load_done), 0);
    repeat (3) @(negedge clk_int);
    start_run();
    wait_final();
    check_tail(1'b1);

    finish_run();
  end

  initial begin
    #1_500_000;
    check(1'b0, "watchdog timeout", 0, 1);
    finish_run();
  end

endmodule